// File: doc/BRIEF.md
# Push-Button Soft Power Controller

This block decides whether a battery-powered device is running or switched off, using one momentary push-button wired as a switch to ground. A press only counts after the button has stayed closed for a debounce window. While the device is off, a press turns on the core supply and issues a power-on reset pulse.

While the device is running, a press does not cut the power. It raises a shutdown request to the CPU and keeps it raised. The device powers down only when firmware sets its power-down bit. Firmware may also set that bit with no request pending. The power-down sequence first strobes a card-interface deactivate signal, then waits a drain interval, then drops the core supply.

Whenever bus power is present, the device is forced on and the button has no effect. Bus power that arrives during a power-down sequence aborts the sequence.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset with bus power absent, the block is off: `core_en`, `por_out`, `off_req` and `card_deact` are all 0.
- R2: While `vbus_ok` is high, `core_en` is 1 from the second clock edge onward, and `pwrdn_bit` has no effect.
- R3: While `vbus_ok` is high, a debounced press never raises `off_req`.
- R4: `btn_n` is active low and passes through a two-stage synchronizer. A press is recognised only after the synchronized input has been low for DEB_CYCLES consecutive cycles. A release restarts the count, and a continuous hold yields exactly one press event.
- R5: A press while off raises `core_en`. `por_out` is 1 during the first POR_CYCLES cycles that `core_en` is high, starting with the cycle in which `core_en` rises.
- R6: A press while on sets `off_req`. It stays at 1 whatever the button does afterwards, until the block enters the off mode or a shutdown is aborted.
- R7: `pwrdn_bit` sampled high while on, with bus power absent, produces a one-cycle `card_deact` pulse. `core_en` falls exactly DRAIN_CYCLES+1 cycles after that pulse, and `off_req` reads 0 once the block is off.
- R8: The power-down sequence of R7 also runs when no shutdown request is pending.
- R9: `vbus_ok` rising during the deactivate or drain phase returns the block to on: `core_en` never drops, `por_out` stays 0 and `off_req` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, asserted when power is first applied |
| btn_n | input | 1 | Raw push-button, low when pressed |
| vbus_ok | input | 1 | Bus power present (synchronous) |
| pwrdn_bit | input | 1 | Firmware power-down command |
| core_en | output | 1 | Core supply and analog enable |
| por_out | output | 1 | Power-on reset, active high |
| off_req | output | 1 | Latched shutdown request to the CPU |
| card_deact | output | 1 | One-cycle card-interface deactivate strobe |

## Verification
The bench releases the button just short of the debounce window, then presses again, to check that the count restarts. A design that keeps a partial count would switch on early. It holds the button far past the window while the block is on, to check that one hold yields one event and that the request stays latched. A toggling design would instead cut the supply. It counts cycles between the deactivate strobe and the supply drop, and between the supply rise and the end of the reset pulse, so that a drop without the strobe or an off-by-one in either counter is caught. Bus power is raised in the middle of a power-down sequence to check the abort. A design that ignored it would drop the supply or issue a fresh reset.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int CLK_HZ      = 32768,
  parameter int DEB_MS      = 75,
  parameter int POR_CYCLES  = 16,
  parameter int DRAIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  input  logic vbus_ok,
  input  logic pwrdn_bit,
  output logic core_en,
  output logic por_out,
  output logic off_req,
  output logic card_deact
);
  localparam int DEB_CYCLES = (CLK_HZ / 1000) * DEB_MS;
  localparam int DW = $clog2(DEB_CYCLES + 1);
  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam int RW = $clog2(DRAIN_CYCLES + 1);

  typedef enum logic [1:0] {S_OFF, S_ON, S_DEACT, S_DRAIN} mode_t;
  mode_t st, nxt;

  logic [1:0]    sync;
  logic [DW-1:0] deb_cnt;
  logic [PW-1:0] por_cnt;
  logic [RW-1:0] drain_cnt;
  logic          press;

  wire btn_s = sync[1];
  assign press = !btn_s && (deb_cnt == DW'(DEB_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], btn_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            deb_cnt <= '0;
    else if (btn_s)                        deb_cnt <= '0;
    else if (deb_cnt != DW'(DEB_CYCLES))   deb_cnt <= deb_cnt + 1'b1;

  always_comb begin
    nxt = st;
    case (st)
      S_OFF:   if (vbus_ok || press) nxt = S_ON;
      S_ON:    if (!vbus_ok && pwrdn_bit) nxt = S_DEACT;
      S_DEACT: nxt = vbus_ok ? S_ON : S_DRAIN;
      S_DRAIN: if (vbus_ok) nxt = S_ON;
               else if (drain_cnt == '0) nxt = S_OFF;
      default: nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_OFF;
    else        st <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            por_cnt <= '0;
    else if (st == S_OFF && nxt == S_ON)   por_cnt <= PW'(POR_CYCLES);
    else if (por_cnt != '0)                por_cnt <= por_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              drain_cnt <= '0;
    else if (st == S_DEACT)                  drain_cnt <= RW'(DRAIN_CYCLES - 1);
    else if (st == S_DRAIN && drain_cnt != '0) drain_cnt <= drain_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                   off_req <= 1'b0;
    else if (nxt == S_OFF || (st != S_ON && nxt == S_ON)) off_req <= 1'b0;
    else if (st == S_ON && press && !vbus_ok)     off_req <= 1'b1;

  assign core_en    = (st != S_OFF);
  assign por_out    = (por_cnt != '0);
  assign card_deact = (st == S_DEACT);

  AST_VBUS_FORCES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vbus_ok) && $past(rst_n) |-> core_en);  // R2
  AST_NO_REQ_ON_VBUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_req) |-> !$past(vbus_ok));  // R3
  AST_POR_AT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_en) && $past(rst_n) |-> por_out);  // R5
  AST_POR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    por_out |-> core_en);  // R5
  AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    off_req && st == S_ON && !pwrdn_bit |=> off_req);  // R6
  AST_DEACT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    card_deact |=> !card_deact);  // R7
  AST_NO_DIRECT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_en) |-> $past(st) == S_DRAIN && !$past(card_deact));  // R7
  AST_ABORT_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_ok && core_en |=> core_en && !card_deact);  // R9
endmodule

// File: tb/pwr_mode_ctl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctl_bench;
  localparam int DEB   = 20;
  localparam int POR   = 4;
  localparam int DRAIN = 3;

  logic clk = 0, rst_n = 0, btn_n = 1, vbus_ok = 0, pwrdn_bit = 0;
  logic core_en, por_out, off_req, card_deact;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_mode_ctl #(.CLK_HZ(20000), .DEB_MS(1), .POR_CYCLES(POR), .DRAIN_CYCLES(DRAIN))
    u_pwr_mode_ctl (.clk(clk), .rst_n(rst_n), .btn_n(btn_n), .vbus_ok(vbus_ok),
                    .pwrdn_bit(pwrdn_bit), .core_en(core_en), .por_out(por_out),
                    .off_req(off_req), .card_deact(card_deact));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_btn(input int n);
    btn_n = 0; cyc(n); btn_n = 1; cyc(4);
  endtask

  task automatic t_reset;
    rst_n = 0; vbus_ok = 0; cyc(3);
    chk("R1 core_en", core_en, 0); chk("R1 por_out", por_out, 0);
    chk("R1 off_req", off_req, 0); chk("R1 card_deact", card_deact, 0);
    rst_n = 1; cyc(3);
    chk("R1 core_en after release", core_en, 0);
  endtask

  task automatic t_debounce_restart;
    hold_btn(DEB - 3);
    chk("R4 short hold ignored", core_en, 0);
    btn_n = 0; cyc(DEB - 3); btn_n = 1; cyc(1);
    btn_n = 0; cyc(DEB - 3); btn_n = 1; cyc(4);
    chk("R4 release restarts count", core_en, 0);
  endtask

  task automatic t_power_on;
    int en_cycles = 0, por_cycles = 0, first_por = -1;
    btn_n = 0;
    for (int i = 0; i < DEB + 12; i++) begin
      cyc(1);
      if (core_en) begin
        if (en_cycles == 0) first_por = por_out;
        en_cycles++;
        if (por_out) por_cycles++;
      end
    end
    btn_n = 1; cyc(4);
    chk("R5 core_en up", core_en, 1);
    chk("R5 por at enable rise", first_por, 1);
    chk("R5 por length", por_cycles, POR);
    chk("R4 single event, no request", off_req, 0);
  endtask

  task automatic t_request;
    hold_btn(DEB + 30);
    chk("R6 request set", off_req, 1);
    chk("R6 still on", core_en, 1);
    cyc(10);
    chk("R6 request held after release", off_req, 1);
    hold_btn(DEB + 6);
    chk("R6 request held after 2nd press", off_req, 1);
  endtask

  task automatic t_shutdown(input string req);
    int seen = 0, gap = 0, pulses = 0;
    bit after = 0;
    pwrdn_bit = 1;
    for (int i = 0; i < DRAIN + 10; i++) begin
      cyc(1);
      if (card_deact) begin pulses++; after = 1; gap = 0; chk({req, " en during strobe"}, core_en, 1); end
      else if (after && core_en) gap++;
      if (!core_en && seen == 0) seen = 1;
    end
    pwrdn_bit = 0;
    chk({req, " strobe count"}, pulses, 1);
    chk({req, " drain gap"}, gap + 1, DRAIN + 1);
    chk({req, " core off"}, core_en, 0);
    chk({req, " req cleared"}, off_req, 0);
  endtask

  task automatic t_abort;
    int dropped = 0, por_seen = 0;
    hold_btn(DEB + 6);
    chk("R9 request before abort", off_req, 1);
    pwrdn_bit = 1; cyc(1);
    chk("R9 in deactivate", card_deact, 1);
    vbus_ok = 1;
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      if (!core_en) dropped++;
      if (por_out) por_seen++;
    end
    chk("R9 supply kept", dropped, 0);
    chk("R9 no reset", por_seen, 0);
    chk("R9 request cleared", off_req, 0);
    chk("R2 pwrdn ignored with bus", core_en, 1);
    pwrdn_bit = 0;
  endtask

  task automatic t_vbus_button;
    hold_btn(DEB + 10);
    chk("R3 no request with bus", off_req, 0);
    chk("R2 still on", core_en, 1);
    vbus_ok = 0; cyc(3);
    chk("R2 stays on after bus leaves", core_en, 1);
  endtask

  task automatic t_vbus_reset;
    rst_n = 0; vbus_ok = 1; cyc(2); rst_n = 1; cyc(2);
    chk("R2 on after reset with bus", core_en, 1);
    vbus_ok = 0; cyc(2);
    t_shutdown("R8");
  endtask

  initial begin
    t_reset();
    t_debounce_restart();
    t_power_on();
    t_shutdown("R8");
    t_power_on();
    t_request();
    t_shutdown("R7");
    t_power_on();
    t_abort();
    t_vbus_button();
    t_vbus_reset();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule